// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Write-Cycle Polling

This block is the slave side of a two-wire serial bus in front of a byte-wide EEPROM array of 2^ADDR_W locations. It takes the raw clock and data lines, resynchronises them to the system clock, and recognises START and STOP conditions. It drives the data line only as an open-drain pull-down enable. A host can write single bytes and read bytes in four ways: random read (a dummy write followed by a repeated START), current-address read, sequential read, and set-address-only.

Each byte write commits on the closing STOP and then starts an internal write cycle of WRITE_CYCLES clocks. While that cycle runs, the slave answers no device address. A host therefore polls with address bytes until one is acknowledged.

Two further device identifiers stand for a neighbouring register space. The slave acknowledges them but does not store what is written to them. An access to that space sets a flag. While the flag is set, a current-address read of the array is refused until a random read has been made.

Top module: `twi_eeprom_slave`

## Requirements
- R1: A byte write reaches the array and starts the write cycle only when STOP follows the acknowledged data byte. A repeated START after the data byte discards the byte and starts no cycle. A STOP right after the word address starts no cycle either.
- R2: While the write cycle runs, every device address byte is left unacknowledged, whether its R/W bit (bit 0, 0 = write) is 0 or 1. The slave then keeps SDA released until the next START.
- R3: The write cycle lasts exactly WRITE_CYCLES clocks. After it ends, a valid device address is acknowledged again.
- R4: Random read returns the byte stored at the word address that was sent in the dummy write. The sequence is: device address with write, word address, repeated START, device address with read.
- R5: A STOP directly after the word address sets the address pointer to that word address, and the slave returns to standby.
- R6: When the host acknowledges a data byte, the next byte follows at pointer+1, wrapping from the top address to 0. A host NACK ends the read.
- R7: The pointer advances by one after each array byte read or written, so a current-address read (device address with read, with no word address sent first) returns the byte after the last one accessed.
- R8: Device identifiers are the upper seven bits of the address byte, sent MSB first. 1010000 selects the array. 1010111 and 1010010 select the other register space: the slave acknowledges them and their written bytes, discards those bytes, and returns 0xFF on reads. Any other identifier is not acknowledged.
- R9: After an access to the other register space, a current-address read of the array is not acknowledged. A random read of the array is still allowed, and it re-enables current-address reads.
- R10: A write carries only one data byte. A second data byte in the same transfer is not acknowledged and is not stored.
- R11: Reset releases SDA, clears the write cycle and sets the address pointer to 0. The array contents are kept across reset.
- R12: The slave changes its SDA drive only after an SCL falling edge, or when it releases the line at a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench polls straight after a write with both R/W values. A slave that checked busy on write addresses only would acknowledge the read poll. A timer that is too short would acknowledge the first poll.

The bench aborts a write with a repeated START and then sends a surplus second data byte. A design that commits on the data ACK would overwrite the array. A design that accepts page data would store the extra byte at the next address.

A sequential read starts at the top address. A pointer that does not wrap, or that does not advance on the final NACKed byte, would give the wrong second byte or the wrong follow-up current read.

An access to the other register space is followed by a refused current-address read and then an accepted random read. A design with no such flag, or one that never clears it, fails one side of that pair.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_DEVACK,
    ST_WORD,
    ST_WORDACK,
    ST_DATA,
    ST_DATAACK,
    ST_TX,
    ST_MACK
  } twi_state_t;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LEN = SYNC_STAGES + 1;

  logic [LEN-1:0] scl_sh;
  logic [LEN-1:0] sda_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[LEN-2:0], scl_i};
      sda_sh <= {sda_sh[LEN-2:0], sda_i};
    end
  end

  // index LEN-2 is the synchronised value, LEN-1 the previous one
  logic scl_now, scl_old, sda_now, sda_old;
  assign scl_now = scl_sh[LEN-2];
  assign scl_old = scl_sh[LEN-1];
  assign sda_now = sda_sh[LEN-2];
  assign sda_old = sda_sh[LEN-1];

  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/twi_wr_timer.sv
module twi_wr_timer #(
  parameter int WRITE_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic busy
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (kick) begin
      busy   <= 1'b1;
      remain <= CNT_W'(WRITE_CYCLES - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/twi_mem.sv
module twi_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/twi_slave_fsm.sv
module twi_slave_fsm
  import twi_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter int               DATA_W   = 8,
  parameter logic [DATA_W-2:0] EE_ID    = 7'b1010000,
  parameter logic [DATA_W-2:0] ALT_ID_A = 7'b1010111,
  parameter logic [DATA_W-2:0] ALT_ID_B = 7'b1010010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              busy,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] ptr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sda_oe
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  twi_state_t        state;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] txsh;
  logic              rd_mode, ee_sel, alt_flag, addr_set, pending, mack;

  // address-byte decode
  logic [DATA_W-2:0] dev_id;
  logic              dev_rd, hit_ee, hit_alt, cur_blocked, addr_ok;
  logic [DATA_W-1:0] tx_byte;
  logic              byte_full;

  always_comb begin
    dev_id      = shreg[DATA_W-1:1];
    dev_rd      = shreg[0];
    hit_ee      = (dev_id == EE_ID);
    hit_alt     = (dev_id == ALT_ID_A) || (dev_id == ALT_ID_B);
    cur_blocked = hit_ee && dev_rd && alt_flag && !addr_set;
    addr_ok     = (hit_ee || hit_alt) && !busy && !cur_blocked;
    tx_byte     = ee_sel ? rdata : '1;
    byte_full   = (bitcnt == FULL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
      rd_mode  <= 1'b0;
      ee_sel   <= 1'b0;
      alt_flag <= 1'b0;
      addr_set <= 1'b0;
      pending  <= 1'b0;
      mack     <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        addr_set <= 1'b0;
        pending  <= 1'b0;
        if (pending) begin
          wr_en   <= 1'b1;
          wr_addr <= ptr;
          ptr     <= ptr + 1'b1;
        end
      end else if (start_det) begin
        state   <= ST_DEVADR;
        bitcnt  <= '0;
        sda_oe  <= 1'b0;
        pending <= 1'b0;
      end else begin
        case (state)
          ST_DEVADR, ST_WORD, ST_DATA: begin
            if (scl_rise && !byte_full) begin
              shreg  <= {shreg[DATA_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && byte_full) begin
              case (state)
                ST_DEVADR: begin
                  if (addr_ok) begin
                    sda_oe  <= 1'b1;
                    state   <= ST_DEVACK;
                    rd_mode <= dev_rd;
                    ee_sel  <= hit_ee;
                    if (hit_alt)     alt_flag <= 1'b1;
                    else if (dev_rd) alt_flag <= 1'b0;
                  end else begin
                    sda_oe <= 1'b0;
                    state  <= ST_IDLE;
                  end
                end
                ST_WORD: begin
                  ptr      <= ADDR_W'(shreg);
                  addr_set <= 1'b1;
                  sda_oe   <= 1'b1;
                  state    <= ST_WORDACK;
                end
                default: begin
                  if (!ee_sel) begin
                    sda_oe <= 1'b1;
                    state  <= ST_DATAACK;
                  end else if (!pending) begin
                    pending <= 1'b1;
                    wr_data <= shreg;
                    sda_oe  <= 1'b1;
                    state   <= ST_DATAACK;
                  end else begin
                    sda_oe <= 1'b0;
                    state  <= ST_IDLE;
                  end
                end
              endcase
            end
          end
          ST_DEVACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rd_mode) begin
                sda_oe <= ~tx_byte[DATA_W-1];
                txsh   <= tx_byte << 1;
                state  <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ee_sel ? ST_WORD : ST_DATA;
              end
            end
          end
          ST_WORDACK, ST_DATAACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_DATA;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == LAST) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
                if (ee_sel) ptr <= ptr + 1'b1;
              end else begin
                sda_oe <= ~txsh[DATA_W-1];
                txsh   <= txsh << 1;
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                bitcnt <= '0;
                sda_oe <= ~tx_byte[DATA_W-1];
                txsh   <= tx_byte << 1;
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int               ADDR_W       = 8,
  parameter int               DATA_W       = 8,
  parameter int               SYNC_STAGES  = 2,
  parameter int               WRITE_CYCLES = 1000000,
  parameter logic [DATA_W-2:0] EE_ID        = 7'b1010000,
  parameter logic [DATA_W-2:0] ALT_ID_A     = 7'b1010111,
  parameter logic [DATA_W-2:0] ALT_ID_B     = 7'b1010010
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              busy, wr_en;
  logic [ADDR_W-1:0] ptr, wr_addr;
  logic [DATA_W-1:0] wr_data, rdata;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_wr_timer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .kick(wr_en), .busy(busy)
  );

  twi_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(ptr), .rdata(rdata)
  );

  twi_slave_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .EE_ID(EE_ID), .ALT_ID_A(ALT_ID_A), .ALT_ID_B(ALT_ID_B)
  ) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .busy(busy), .rdata(rdata), .ptr(ptr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk #(
  parameter int WRITE_CYCLES = 1000000
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic wr_en,
  input logic stop_det,
  input logic start_det,
  input logic scl_fall,
  input logic sda_oe
);
  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_cnt <= 0;
    else              busy_cnt <= busy_cnt + 1;
  end

  // R1: array commit only right after a STOP
  assert_commit_on_stop_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(stop_det));

  // R2: no new write can be accepted during a running cycle
  assert_no_write_busy_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !busy);

  // R3: cycle begins after a commit
  assert_busy_from_commit_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en));

  // R3: cycle length
  assert_busy_length_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == WRITE_CYCLES));

  // R12: drive changes follow SCL fall, START or STOP
  assert_sda_change_R12: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));
endmodule

bind twi_eeprom_slave twi_eeprom_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .wr_en(wr_en), .stop_det(stop_det),
  .start_det(start_det), .scl_fall(scl_fall), .sda_oe(sda_oe)
);

// File: tb/sim_twi_eeprom_slave.sv
`timescale 1ns/1ps
module sim_twi_eeprom_slave;
  localparam int WCYC = 1200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  int   n_chk = 0;
  int   n_err = 0;
  int   oe_glitch = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  twi_eeprom_slave #(.WRITE_CYCLES(WCYC)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (10) @(posedge clk);
    #1 rst = 1'b0;
    #20;
  endtask

  task automatic b_start();
    sda_m = 1'b1; #50; scl = 1'b1; #50; sda_m = 1'b0; #50; scl = 1'b0; #50;
  endtask

  task automatic b_stop();
    sda_m = 1'b0; #50; scl = 1'b1; #50; sda_m = 1'b1; #100;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #50; scl = 1'b1; #100; scl = 1'b0; #50;
    end
    sda_m = 1'b1; #50; scl = 1'b1; #50; ack = ~sda_bus; #50; scl = 1'b0; #50;
  endtask

  task automatic recv_byte(input bit host_ack, output logic [7:0] d);
    logic oe_a;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; #50; scl = 1'b1; #25; oe_a = sda_oe; #25;
      d[i] = sda_bus; #25;
      if (sda_oe !== oe_a) oe_glitch++;
      #25; scl = 1'b0; #50;
    end
    sda_m = ~host_ack; #50; scl = 1'b1; #100; scl = 1'b0; #50;
  endtask

  task automatic ee_write(input logic [7:0] a, input logic [7:0] d, output logic [2:0] acks);
    b_start();
    send_byte(8'hA0, acks[2]);
    send_byte(a, acks[1]);
    send_byte(d, acks[0]);
    b_stop();
  endtask

  task automatic wait_ready(output int tries);
    logic ak;
    tries = 0;
    for (int i = 0; i < 20; i++) begin
      b_start(); send_byte(8'hA0, ak); b_stop();
      tries++;
      if (ak) break;
    end
  endtask

  task automatic write_wait(input logic [7:0] a, input logic [7:0] d);
    logic [2:0] acks;
    int t;
    ee_write(a, d, acks);
    wait_ready(t);
  endtask

  task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
    logic ak;
    b_start(); send_byte(8'hA0, ak); send_byte(a, ak);
    b_start(); send_byte(8'hA1, ak);
    recv_byte(1'b0, d);
    b_stop();
  endtask

  task automatic cur_read(output logic ak, output logic [7:0] d);
    d = 8'h00;
    b_start(); send_byte(8'hA1, ak);
    if (ak) recv_byte(1'b0, d);
    b_stop();
  endtask

  task automatic t_reset();
    logic ak;
    logic [7:0] d;
    chk(sda_oe == 1'b0, "R11 sda released after reset", sda_oe, 0);
    write_wait(8'h00, 8'h5A);
    write_wait(8'h07, 8'h01);
    do_reset();
    cur_read(ak, d);
    chk(ak == 1'b1, "R11 current read ack after reset", ak, 1);
    chk(d == 8'h5A, "R11 pointer at 0 after reset", d, 8'h5A);
  endtask

  task automatic t_poll();
    logic [2:0] acks;
    logic ak;
    int t;
    ee_write(8'h10, 8'h3C, acks);
    chk(acks == 3'b111, "R8 array write acked", acks, 3'b111);
    b_start(); send_byte(8'hA0, ak); b_stop();
    chk(ak == 1'b0, "R2 write-bit poll nacked while busy", ak, 0);
    b_start(); send_byte(8'hA1, ak); b_stop();
    chk(ak == 1'b0, "R2 read-bit poll nacked while busy", ak, 0);
    wait_ready(t);
    chk(t >= 1 && t <= 6, "R3 poll acked after cycle", t, 3);
  endtask

  task automatic t_random();
    logic [7:0] d;
    rand_read(8'h10, d);
    chk(d == 8'h3C, "R4 random read", d, 8'h3C);
  endtask

  task automatic t_current();
    logic ak;
    logic [7:0] d;
    write_wait(8'h21, 8'hB2);
    write_wait(8'h20, 8'hA1);
    cur_read(ak, d);
    chk(ak && d == 8'hB2, "R7 current read after write", d, 8'hB2);
  endtask

  task automatic t_wrap();
    logic ak;
    logic [7:0] d0, d1, d2, d3;
    write_wait(8'hFF, 8'h11);
    write_wait(8'h00, 8'h22);
    write_wait(8'h01, 8'h33);
    write_wait(8'h02, 8'h44);
    b_start(); send_byte(8'hA0, ak); send_byte(8'hFF, ak);
    b_start(); send_byte(8'hA1, ak);
    recv_byte(1'b1, d0);
    recv_byte(1'b1, d1);
    recv_byte(1'b0, d2);
    b_stop();
    chk(d0 == 8'h11, "R6 sequential first byte", d0, 8'h11);
    chk(d1 == 8'h22, "R6 wrap to address 0", d1, 8'h22);
    chk(d2 == 8'h33, "R6 third byte", d2, 8'h33);
    cur_read(ak, d3);
    chk(d3 == 8'h44, "R7 pointer after NACKed byte", d3, 8'h44);
  endtask

  task automatic t_setaddr();
    logic ak;
    logic [7:0] d;
    b_start(); send_byte(8'hA0, ak); send_byte(8'h10, ak); b_stop();
    b_start(); send_byte(8'hA0, ak); b_stop();
    chk(ak == 1'b1, "R1 no cycle after address-only write", ak, 1);
    cur_read(ak, d);
    chk(d == 8'h3C, "R5 set current address", d, 8'h3C);
  endtask

  task automatic t_abort();
    logic ak;
    logic [7:0] d;
    write_wait(8'h40, 8'h44);
    b_start(); send_byte(8'hA0, ak); send_byte(8'h40, ak); send_byte(8'h99, ak);
    b_start(); send_byte(8'hA1, ak);
    chk(ak == 1'b1, "R1 no cycle after repeated START", ak, 1);
    recv_byte(1'b0, d);
    b_stop();
    chk(d == 8'h44, "R1 aborted byte not stored", d, 8'h44);
  endtask

  task automatic t_extra();
    logic a0, a1, a2, a3, ak;
    int t;
    logic [7:0] d;
    write_wait(8'h51, 8'h00);
    b_start(); send_byte(8'hA0, a0); send_byte(8'h50, a1);
    send_byte(8'h55, a2); send_byte(8'h66, a3); b_stop();
    chk(a2 == 1'b1, "R10 first data byte acked", a2, 1);
    chk(a3 == 1'b0, "R10 second data byte nacked", a3, 0);
    wait_ready(t);
    rand_read(8'h50, d);
    chk(d == 8'h55, "R10 first byte stored", d, 8'h55);
    cur_read(ak, d);
    chk(d == 8'h00, "R10 second byte not stored", d, 8'h00);
  endtask

  task automatic t_alt();
    logic ak;
    logic [7:0] d;
    b_start(); send_byte(8'hA2, ak); b_stop();
    chk(ak == 1'b0, "R8 foreign identifier nacked", ak, 0);
    b_start(); send_byte(8'hAE, ak);
    chk(ak == 1'b1, "R8 alternate id 1010111 acked", ak, 1);
    send_byte(8'h05, ak); b_stop();
    chk(ak == 1'b1, "R8 alternate data acked", ak, 1);
    cur_read(ak, d);
    chk(ak == 1'b0, "R9 current read refused after alternate access", ak, 0);
    b_start(); send_byte(8'hA5, ak);
    chk(ak == 1'b1, "R8 alternate id 1010010 read acked", ak, 1);
    recv_byte(1'b0, d); b_stop();
    chk(d == 8'hFF, "R8 alternate read returns all ones", d, 8'hFF);
    rand_read(8'h20, d);
    chk(d == 8'hA1, "R9 random read allowed", d, 8'hA1);
    cur_read(ak, d);
    chk(ak && d == 8'hB2, "R9 current read restored", d, 8'hB2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_poll();
    t_random();
    t_current();
    t_wrap();
    t_setaddr();
    t_abort();
    t_extra();
    t_alt();
    chk(oe_glitch == 0, "R12 drive stable while SCL high", oe_glitch, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule